// File: doc/BRIEF.md
# Hex Record Stream Parser

This block reads a stream of ASCII characters, one per accepted handshake, and decodes the hexadecimal object record format used to load memory images. It waits for the record mark `:`, turns each following pair of hex characters into a byte, and splits the bytes into the record's fields: length, 16-bit load offset, type, payload and checksum. Anything outside a record is skipped, including the CR and LF characters that separate records.

Bytes of a data record are sent out one at a time, each with its position in the record and the record's load offset. Address and start records have their payload collected into one word. When the checksum byte arrives the block pulses a completion strobe that carries the verdict: the checksum result, a shape check of length against type, and an end-of-file flag. Data bytes are sent out before the checksum is known, so a consumer keeps them provisional until the completion strobe. Forming absolute addresses and writing memory are left to the consumer.

Top module: `hexrec_parser`

## Requirements
- R1: While no record is open, every character except `:` (0x3A) is dropped, CR and LF included, and it produces no output pulse.
- R2: Each byte is built from two hex characters, the first giving bits 7..4. The characters 0-9, A-F and a-f are accepted, with the letters standing for 10 to 15.
- R3: After the mark the block reads the length byte, the offset high byte, the offset low byte, the type byte, as many payload bytes as the length gives, and then the checksum byte. For type 0, each payload byte raises `dat_valid` for one cycle, starting the cycle after its second character is accepted. The pulse carries the byte, its index counted from 0, and the 16-bit offset.
- R4: One cycle after the checksum byte's second character is accepted, `rec_done` pulses. `chk_err` is 1 with it when the 8-bit sum of all decoded bytes of the record, checksum included, is not zero. A record with `chk_err` set never has `rec_ok` set.
- R5: `fmt_err` is 1 with `rec_done` when the type is above 5, or when the length differs from the one fixed by the type: 0 for type 1, 2 for types 2 and 4, and 4 for types 3 and 5. Type 0 takes any length. `rec_ok` is 1 only when both `chk_err` and `fmt_err` are 0.
- R6: A character that is not a hex digit, seen while a record is open, ends that record. It raises `char_err` for one cycle with no `rec_done`, is itself discarded (a `:` too), and sends the block back to hunting for the mark.
- R7: For types other than 0, the payload bytes are shifted into `rec_payload` with the first byte highest. The value is right-aligned, with zeros above it, and is shown with `rec_done`. Types 2 and 4 fill bits 15..0, and types 3 and 5 fill bits 31..0.
- R8: `eof_flag` pulses together with `rec_done` only for a type 1 record that has `rec_ok` set.
- R9: `in_ready` is held at 1, so a character is accepted on every clock edge where `in_valid` is 1, including back-to-back characters.
- R10: After reset, `dat_valid`, `rec_done`, `rec_ok`, `chk_err`, `fmt_err`, `eof_flag` and `char_err` are 0, and the block is hunting for the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character present |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted (always 1) |
| dat_valid | output | 1 | Data byte strobe |
| dat_byte | output | 8 | Decoded data byte |
| dat_index | output | 8 | Index of the byte inside its record |
| dat_offset | output | 16 | Load offset of the record |
| rec_done | output | 1 | Record completed (checksum byte decoded) |
| rec_ok | output | 1 | Record passed checksum and shape check |
| chk_err | output | 1 | Checksum mismatch |
| fmt_err | output | 1 | Type unknown or length wrong for type |
| rec_type | output | 8 | Type code of the completed record |
| rec_payload | output | 32 | Payload of address/start records |
| eof_flag | output | 1 | Valid end-of-file record seen |
| char_err | output | 1 | Record aborted by a non-hex character |

## Verification
The embedded assertions check on every cycle the properties that do not depend on the stream contents. Data strobes, completions and aborts never coincide. A data strobe never comes two cycles in a row. A data index always stays below the record length. A hunting cycle is never followed by an output pulse. An end-of-file flag always comes with a good type 1 completion, and either error flag rules out `rec_ok`. The bench covers what depends on the values in the stream: every byte value in both letter cases, every wrong checksum offset, each type combined with a range of lengths, the payload contents, and recovery after aborts and line noise.

// File: rtl/hexrec_parser.sv
module hexrec_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_char,
  output logic        in_ready,
  output logic        dat_valid,
  output logic [7:0]  dat_byte,
  output logic [7:0]  dat_index,
  output logic [15:0] dat_offset,
  output logic        rec_done,
  output logic        rec_ok,
  output logic        chk_err,
  output logic        fmt_err,
  output logic [7:0]  rec_type,
  output logic [31:0] rec_payload,
  output logic        eof_flag,
  output logic        char_err
);

  localparam logic [7:0] MARK = 8'h3A;
  localparam int         POSW = 9;

  typedef enum logic [1:0] {HUNT, HI, LO} st_t;

  st_t              st;
  logic [3:0]       nib_hi;
  logic [POSW-1:0]  pos;
  logic [7:0]       len_q;
  logic [7:0]       sum_q;
  logic [15:0]      off_q;
  logic [7:0]       type_q;
  logic [31:0]      pay_q;
  logic             is_hex;
  logic [3:0]       nval;
  logic             bad_shape;

  assign in_ready = 1'b1;

  always_comb begin
    is_hex = 1'b1;
    nval   = 4'h0;
    if (in_char >= 8'h30 && in_char <= 8'h39)
      nval = in_char[3:0];
    else if ((in_char >= 8'h41 && in_char <= 8'h46) || (in_char >= 8'h61 && in_char <= 8'h66))
      nval = in_char[3:0] + 4'd9;
    else
      is_hex = 1'b0;
  end

  wire [7:0]      byte_v  = {nib_hi, nval};
  wire [7:0]      sum_n   = sum_q + byte_v;
  wire [POSW-1:0] dpos    = pos - POSW'(4);
  wire            past_hd = pos >= POSW'(4);
  wire            in_data = past_hd && (dpos < {1'b0, len_q});
  wire            at_cks  = past_hd && (dpos == {1'b0, len_q});

  always_comb begin
    case (type_q)
      8'd0:       bad_shape = 1'b0;
      8'd1:       bad_shape = len_q != 8'd0;
      8'd2, 8'd4: bad_shape = len_q != 8'd2;
      8'd3, 8'd5: bad_shape = len_q != 8'd4;
      default:    bad_shape = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= HUNT;
      nib_hi      <= 4'h0;
      pos         <= '0;
      len_q       <= 8'h0;
      sum_q       <= 8'h0;
      off_q       <= 16'h0;
      type_q      <= 8'h0;
      pay_q       <= 32'h0;
      dat_valid   <= 1'b0;
      dat_byte    <= 8'h0;
      dat_index   <= 8'h0;
      dat_offset  <= 16'h0;
      rec_done    <= 1'b0;
      rec_ok      <= 1'b0;
      chk_err     <= 1'b0;
      fmt_err     <= 1'b0;
      rec_type    <= 8'h0;
      rec_payload <= 32'h0;
      eof_flag    <= 1'b0;
      char_err    <= 1'b0;
    end else begin
      dat_valid <= 1'b0;
      rec_done  <= 1'b0;
      rec_ok    <= 1'b0;
      chk_err   <= 1'b0;
      fmt_err   <= 1'b0;
      eof_flag  <= 1'b0;
      char_err  <= 1'b0;
      if (in_valid) begin
        case (st)
          HUNT: if (in_char == MARK) begin
            st    <= HI;
            pos   <= '0;
            sum_q <= 8'h0;
            pay_q <= 32'h0;
          end
          HI: if (is_hex) begin
            nib_hi <= nval;
            st     <= LO;
          end else begin
            st       <= HUNT;
            char_err <= 1'b1;
          end
          LO: if (!is_hex) begin
            st       <= HUNT;
            char_err <= 1'b1;
          end else begin
            sum_q <= sum_n;
            pos   <= pos + POSW'(1);
            st    <= HI;
            if (pos == POSW'(0)) len_q        <= byte_v;
            if (pos == POSW'(1)) off_q[15:8]  <= byte_v;
            if (pos == POSW'(2)) off_q[7:0]   <= byte_v;
            if (pos == POSW'(3)) type_q       <= byte_v;
            if (in_data) begin
              if (type_q == 8'd0) begin
                dat_valid  <= 1'b1;
                dat_byte   <= byte_v;
                dat_index  <= dpos[7:0];
                dat_offset <= off_q;
              end else begin
                pay_q <= {pay_q[23:0], byte_v};
              end
            end
            if (at_cks) begin
              st          <= HUNT;
              rec_done    <= 1'b1;
              chk_err     <= sum_n != 8'h0;
              fmt_err     <= bad_shape;
              rec_ok      <= (sum_n == 8'h0) && !bad_shape;
              eof_flag    <= (sum_n == 8'h0) && !bad_shape && (type_q == 8'd1);
              rec_type    <= type_q;
              rec_payload <= pay_q;
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end

  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dat_valid, rec_done, char_err}));

  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |=> !dat_valid);

  assert_index_in_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (dat_index < len_q));

  assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HUNT) |=> (!dat_valid && !rec_done && !char_err));

  assert_chk_blocks_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> (rec_done && !rec_ok));

  assert_fmt_blocks_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (rec_done && !rec_ok));

  assert_eof_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_flag |-> (rec_done && rec_ok && rec_type == 8'd1));

endmodule

// File: tb/hexrec_parser_bench.sv
module hexrec_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h0;
  logic        in_ready, dat_valid, rec_done, rec_ok, chk_err, fmt_err, eof_flag, char_err;
  logic [7:0]  dat_byte, dat_index, rec_type;
  logic [15:0] dat_offset;
  logic [31:0] rec_payload;

  always #4 clk = ~clk;

  hexrec_parser u_hexrec_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_index(dat_index), .dat_offset(dat_offset),
    .rec_done(rec_done), .rec_ok(rec_ok), .chk_err(chk_err), .fmt_err(fmt_err),
    .rec_type(rec_type), .rec_payload(rec_payload), .eof_flag(eof_flag), .char_err(char_err));

  int n_chk = 0, n_fail = 0;
  int n_dat = 0, n_done = 0, n_cerr = 0, n_notready = 0;
  logic [7:0]  cap_b [0:255];
  logic [7:0]  cap_i [0:255];
  logic [15:0] cap_o;
  logic        d_ok, d_chk, d_fmt, d_eof;
  logic [7:0]  d_type;
  logic [31:0] d_pay;
  logic [7:0]  tx [0:255];

  always @(negedge clk) if (rst_n) begin
    if (!in_ready) n_notready++;
    if (dat_valid) begin
      if (n_dat < 256) begin
        cap_b[n_dat] = dat_byte;
        cap_i[n_dat] = dat_index;
      end
      cap_o = dat_offset;
      n_dat++;
    end
    if (rec_done) begin
      d_ok = rec_ok; d_chk = chk_err; d_fmt = fmt_err; d_eof = eof_flag;
      d_type = rec_type; d_pay = rec_payload;
      n_done++;
    end
    if (char_err) n_cerr++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lc ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_char  = 8'h0;
    end
  endtask

  task automatic clear_caps();
    n_dat = 0; n_done = 0; n_cerr = 0;
    d_ok = 0; d_chk = 0; d_fmt = 0; d_eof = 0; d_type = 0; d_pay = 0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lc);
    send_char(hexc(b[7:4], lc));
    send_char(hexc(b[3:0], lc));
  endtask

  task automatic send_rec(input logic [7:0] len, input logic [15:0] off, input logic [7:0] typ,
                          input bit lc, input logic [7:0] delta);
    logic [7:0] sum;
    clear_caps();
    sum = len + off[15:8] + off[7:0] + typ;
    for (int i = 0; i < len; i++) sum = sum + tx[i];
    send_char(8'h3A);
    send_byte(len, lc);
    send_byte(off[15:8], lc);
    send_byte(off[7:0], lc);
    send_byte(typ, lc);
    for (int i = 0; i < len; i++) send_byte(tx[i], lc);
    send_byte(8'h00 - sum + delta, lc);
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string hw;
    logic  exp_fmt;
    logic [31:0] p;
    hw = "Hello, World\n";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R9 ready
    chk("R10 pulses after reset", {dat_valid, rec_done, rec_ok, chk_err, fmt_err, eof_flag, char_err}, 0);
    chk("R9 ready after reset", in_ready, 1);

    // R3/R4 published example, sent back to back
    clear_caps();
    send_str(":0D00000048656C6C6F2C20576F726C640AA1");
    idle(3);
    chk("R3 example byte count", n_dat, 13);
    for (int i = 0; i < 13; i++) begin
      chk("R3 example byte", cap_b[i], hw[i]);
      chk("R3 example index", cap_i[i], i);
    end
    chk("R3 example offset", cap_o, 0);
    chk("R4 example done", n_done, 1);
    chk("R4 example checksum ok", {d_ok, d_chk}, 2'b10);

    // R8 end of file
    clear_caps();
    send_str(":00000001FF");
    idle(3);
    chk("R8 eof flag", {n_done[7:0], d_eof, d_ok}, {8'd1, 2'b11});

    // R2 all byte values, upper case then lower case
    for (int i = 0; i < 255; i++) tx[i] = i[7:0];
    send_rec(8'd255, 16'hFFF0, 8'd0, 1'b0, 8'd0);
    chk("R3 sweep count upper", n_dat, 255);
    for (int i = 0; i < 255; i++) begin
      chk("R2 byte upper", cap_b[i], i);
      chk("R3 index upper", cap_i[i], i);
    end
    chk("R3 offset upper", cap_o, 16'hFFF0);
    chk("R4 sweep upper ok", d_ok, 1);
    for (int i = 0; i < 255; i++) tx[i] = 8'd255 - i[7:0];
    send_rec(8'd255, 16'h1234, 8'd0, 1'b1, 8'd0);
    chk("R3 sweep count lower", n_dat, 255);
    for (int i = 0; i < 255; i++) chk("R2 byte lower", cap_b[i], 255 - i);
    chk("R3 offset lower", cap_o, 16'h1234);
    chk("R4 sweep lower ok", d_ok, 1);

    // R4 every wrong checksum value
    for (int d = 1; d < 256; d++) begin
      tx[0] = d[7:0];
      send_rec(8'd1, d[15:0] * 16'd3, 8'd0, d[0], d[7:0]);
      chk("R4 bad checksum flagged", {n_done[7:0], d_chk, d_ok}, {8'd1, 2'b10});
    end

    // R5/R7/R8 type and length sweep
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l < 6; l++) begin
        for (int i = 0; i < l; i++) tx[i] = 8'h11 * (i[7:0] + 8'd1) + t[7:0];
        exp_fmt = (t > 5) || (t == 1 && l != 0) || ((t == 2 || t == 4) && l != 2) ||
                  ((t == 3 || t == 5) && l != 4);
        send_rec(l[7:0], 16'h0000, t[7:0], t[0], 8'd0);
        chk("R5 shape error", d_fmt, exp_fmt);
        chk("R5 ok verdict", d_ok, !exp_fmt);
        chk("R5 type reported", d_type, t);
        chk("R8 eof only for good type 1", d_eof, (t == 1) && !exp_fmt);
        chk("R3 data strobes only for type 0", n_dat, (t == 0) ? l : 0);
        if (!exp_fmt && t >= 2) begin
          p = 32'h0;
          for (int i = 0; i < l; i++) p = {p[23:0], tx[i]};
          chk("R7 payload", d_pay, p);
        end
      end
    end

    // R1 noise and line endings
    clear_caps();
    send_str("Zq9\r\n,F0\r\n");
    idle(3);
    chk("R1 noise silent", n_dat + n_done + n_cerr, 0);
    tx[0] = 8'hA5; tx[1] = 8'h5A;
    send_rec(8'd2, 16'h0000, 8'd4, 1'b0, 8'd0);
    chk("R1 record after noise", {d_ok, d_pay[15:0]}, {1'b1, 16'hA55A});

    // R6 abort on bad characters
    clear_caps();
    send_str(":0G");
    idle(3);
    chk("R6 abort pulse", n_cerr, 1);
    chk("R6 no completion", n_done, 0);
    clear_caps();
    send_str("0100000000FF");
    idle(3);
    chk("R6 hex ignored after abort", n_dat + n_done + n_cerr, 0);
    clear_caps();
    send_str(":0:00000001FF\r\n");
    idle(3);
    chk("R6 inner mark aborts", n_cerr, 1);
    chk("R6 inner mark discarded", n_done + n_dat, 0);
    tx[0] = 8'h77;
    send_rec(8'd1, 16'h00C0, 8'd0, 1'b0, 8'd0);
    chk("R6 recovery", {n_dat[7:0], cap_b[0], d_ok}, {8'd1, 8'h77, 1'b1});

    chk("R9 ready held", n_notready, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule